// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block holds the digital counters of an integer-N frequency synthesizer. A reference divider counts reference-clock cycles and emits one pulse per comparison period. A programmable divider counts oscillator-side cycles in three stages. The first stage is a prescaler whose modulus is either 32 or 33. The second is a main counter that counts prescaler periods. The third is a swallow counter that holds the prescaler at 33 for the first part of each output period. Together they divide the oscillator clock by N = 32·M + S, where M is the main ratio and S is the swallow value.

A test route feeds one internal signal to a shared output pin and drives a tri-state enable for that pin. The signal can be the lock level, either divider's pulse, or a slowed copy of the reference pulse train. The analog phase detector, the charge pump and the oscillator are outside this block. The lock level arrives as an input. A synchronous power-down input clears every counter in both clock domains.

Top module: `synth_divider_chain`

## Requirements
- R1: The reference divide code selects the reference ratio R: 00 gives 3, 01 gives 4, 10 gives 6 and 11 gives 8. After power-down is released, the first `ref_pulse` appears R-1 reference cycles later, and every following pulse comes exactly R cycles after the previous one.
- R2: `ref_pulse` is high for exactly one reference cycle per period.
- R3: The main code selects the main ratio M: 00 gives 32, 01 gives 33, 10 gives 34 and 11 gives 35. `pc_pulse` recurs every N = 32·M + S oscillator cycles, and the first pulse after release comes N-1 cycles after release.
- R4: `pc_pulse` is high for exactly one oscillator cycle per period.
- R5: In each output period, `mod33` stays high for the first S prescaler periods and low for the rest. Each of those first S periods lasts 33 cycles, so `mod33` is high for exactly 33·S cycles per output period. With S = 0 it never rises. `mod33` changes only at a prescaler period boundary.
- R6: While `pwr_dn` is high at a clock edge, that domain's counters clear. From the next edge on, `ref_pulse`, `pc_pulse` and `mod33` stay low, and so do both slowed reference copies.
- R7: The low two bits of `test_sel` pick the routed signal: 00 the lock level, 01 `ref_pulse`, 10 `pc_pulse`, 11 a slowed reference copy. Bit 2 set drives `test_oe` low (pin in high impedance); bit 2 clear drives it high.
- R8: The divide-by-2048 copy (`test_sel` 011) rises after the 1024th reference pulse. The divide-by-2 copy (`test_sel` 111) toggles one cycle after each reference pulse. Both start low after power-down.
- R9: With `test_sel` 000 or 100, `test_out` follows `lock_in`, which is 1 when locked and 0 when unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator-side clock |
| pwr_dn | input | 1 | Synchronous active-high power-down, sampled in both domains |
| ref_code | input | 2 | Reference divide code |
| main_code | input | 2 | Main counter code |
| swallow_val | input | 5 | Swallow count S, 0 to 31 |
| test_sel | input | 3 | Test route select; bit 2 requests high impedance |
| lock_in | input | 1 | Lock level from the phase detector |
| ref_pulse | output | 1 | One-cycle reference divider pulse |
| pc_pulse | output | 1 | One-cycle programmable divider pulse |
| mod33 | output | 1 | Prescaler modulus control, 1 selects 33 |
| test_out | output | 1 | Value for the lock/test pin |
| test_oe | output | 1 | Drive enable for the lock/test pin |

## Verification
The assertions assume that `pwr_dn` stays high across at least one rising edge of each clock before it is released. They also assume that the main code and swallow value only matter at a reload, since both counters sample them only there. The reference code, by contrast, is read live. The bench changes codes only while power-down is held, and it keeps the two clocks phase-aligned: every falling edge of the reference clock is also a falling edge of the oscillator clock, so a single release time starts both domains together.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;

    localparam int REF_CNT_W  = 3;
    localparam int PRESC_LO   = 32;
    localparam int PRESC_W    = $clog2(PRESC_LO + 1);
    localparam int MAIN_BASE  = 32;
    localparam int MAIN_CNT_W = 6;
    localparam int SWAL_W     = 5;
    localparam int TAP_W      = 11;

    typedef enum logic [1:0] {
        ROUTE_LOCK = 2'b00,
        ROUTE_REF  = 2'b01,
        ROUTE_PC   = 2'b10,
        ROUTE_SLOW = 2'b11
    } route_e;

    typedef struct packed {
        logic   hiz;
        route_e route;
    } test_sel_t;

    typedef struct packed {
        logic [MAIN_CNT_W-1:0] main_cnt;
        logic [SWAL_W-1:0]     swal_cnt;
    } pc_state_t;

    function automatic logic [REF_CNT_W:0] ref_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return (REF_CNT_W+1)'(3);
            2'b01:   return (REF_CNT_W+1)'(4);
            2'b10:   return (REF_CNT_W+1)'(6);
            default: return (REF_CNT_W+1)'(8);
        endcase
    endfunction

    function automatic logic [MAIN_CNT_W-1:0] main_ratio(input logic [1:0] code);
        return MAIN_CNT_W'(MAIN_BASE) + MAIN_CNT_W'(code);
    endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider
    import syn_div_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic [1:0] code,
    output logic       pulse
);

    logic [REF_CNT_W-1:0] cnt;
    logic [REF_CNT_W:0]   last;

    assign last  = ref_ratio(code) - 1'b1;
    assign pulse = !clr && ({1'b0, cnt} >= last);

    always_ff @(posedge clk) begin
        if (clr || pulse) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (clr)
        pulse |=> !pulse); // R2

endmodule

// File: rtl/ref_tap_divider.sv
module ref_tap_divider
    import syn_div_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic pulse,
    output logic div2,
    output logic slow
);

    logic [TAP_W-1:0] taps;

    always_ff @(posedge clk) begin
        if (clr)        taps <= '0;
        else if (pulse) taps <= taps + 1'b1;
    end

    assign div2 = taps[0];
    assign slow = taps[TAP_W-1];

    AST_TAP_TOGGLE: assert property (@(posedge clk) disable iff (clr)
        pulse |=> (div2 != $past(div2))); // R8
    AST_TAP_HOLD: assert property (@(posedge clk) disable iff (clr)
        !pulse |=> $stable(taps)); // R8

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
    import syn_div_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic sel33,
    output logic wrap
);

    logic [PRESC_W-1:0] cnt;
    logic [PRESC_W-1:0] last;

    assign last = sel33 ? PRESC_W'(PRESC_LO) : PRESC_W'(PRESC_LO - 1);
    assign wrap = !clr && (cnt == last);

    always_ff @(posedge clk) begin
        if (clr || wrap) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    AST_MODULUS_STABLE: assert property (@(posedge clk) disable iff (clr)
        !wrap |=> $stable(sel33)); // R5

endmodule

// File: rtl/swallow_main_counter.sv
module swallow_main_counter
    import syn_div_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic [1:0]        main_code,
    input  logic [SWAL_W-1:0] swallow,
    input  logic              wrap,
    output logic              sel33,
    output logic              out_pulse
);

    pc_state_t st;

    assign sel33     = !clr && (st.swal_cnt != '0);
    assign out_pulse = wrap && (st.main_cnt == MAIN_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (clr || out_pulse) begin
            st.main_cnt <= main_ratio(main_code);
            st.swal_cnt <= swallow;
        end else if (wrap) begin
            st.main_cnt <= st.main_cnt - 1'b1;
            if (st.swal_cnt != '0) st.swal_cnt <= st.swal_cnt - 1'b1;
        end
    end

    AST_PC_ONE_CYCLE: assert property (@(posedge clk) disable iff (clr)
        out_pulse |=> !out_pulse); // R4
    AST_RELOAD_MODULUS: assert property (@(posedge clk) disable iff (clr)
        out_pulse |=> (sel33 == ($past(swallow) != '0))); // R5

endmodule

// File: rtl/test_route_mux.sv
module test_route_mux
    import syn_div_pkg::*;
(
    input  test_sel_t sel,
    input  logic      lock,
    input  logic      ref_p,
    input  logic      pc_p,
    input  logic      div2,
    input  logic      slow,
    output logic      pin,
    output logic      oe
);

    always_comb begin
        case (sel.route)
            ROUTE_LOCK: pin = lock;
            ROUTE_REF:  pin = ref_p;
            ROUTE_PC:   pin = pc_p;
            default:    pin = sel.hiz ? div2 : slow;
        endcase
    end

    assign oe = !sel.hiz;

endmodule

// File: rtl/synth_divider_chain.sv
module synth_divider_chain
    import syn_div_pkg::*;
(
    input  logic        ref_clk,
    input  logic        vco_clk,
    input  logic        pwr_dn,
    input  logic [1:0]  ref_code,
    input  logic [1:0]  main_code,
    input  logic [4:0]  swallow_val,
    input  logic [2:0]  test_sel,
    input  logic        lock_in,
    output logic        ref_pulse,
    output logic        pc_pulse,
    output logic        mod33,
    output logic        test_out,
    output logic        test_oe
);

    logic      presc_wrap;
    logic      div2;
    logic      slow;
    test_sel_t sel_s;

    assign sel_s = test_sel_t'(test_sel);

    ref_divider u_ref (
        .clk   (ref_clk),
        .clr   (pwr_dn),
        .code  (ref_code),
        .pulse (ref_pulse)
    );

    ref_tap_divider u_taps (
        .clk   (ref_clk),
        .clr   (pwr_dn),
        .pulse (ref_pulse),
        .div2  (div2),
        .slow  (slow)
    );

    dual_mod_prescaler u_presc (
        .clk   (vco_clk),
        .clr   (pwr_dn),
        .sel33 (mod33),
        .wrap  (presc_wrap)
    );

    swallow_main_counter u_pc (
        .clk       (vco_clk),
        .clr       (pwr_dn),
        .main_code (main_code),
        .swallow   (swallow_val),
        .wrap      (presc_wrap),
        .sel33     (mod33),
        .out_pulse (pc_pulse)
    );

    test_route_mux u_mux (
        .sel   (sel_s),
        .lock  (lock_in),
        .ref_p (ref_pulse),
        .pc_p  (pc_pulse),
        .div2  (div2),
        .slow  (slow),
        .pin   (test_out),
        .oe    (test_oe)
    );

endmodule

// File: tb/test_synth_divider_chain.sv
module test_synth_divider_chain;

    localparam int CLK_PERIOD = 4;
    localparam int REF_PERIOD = 3 * CLK_PERIOD;
    localparam int NVEC = 6;
    // columns: ref_code, main_code, swallow, expected R, expected N
    localparam int VEC [NVEC][5] = '{
        '{0, 0,  0, 3, 1024},
        '{1, 1,  5, 4, 1061},
        '{2, 2, 17, 6, 1105},
        '{3, 3, 31, 8, 1151},
        '{0, 3,  1, 3, 1121},
        '{1, 0, 31, 4, 1055}
    };

    logic       ref_clk = 0;
    logic       vco_clk = 0;
    logic       pwr_dn  = 1;
    logic [1:0] ref_code = 0;
    logic [1:0] main_code = 0;
    logic [4:0] swallow_val = 0;
    logic [2:0] test_sel = 0;
    logic       lock_in = 0;
    logic       ref_pulse, pc_pulse, mod33, test_out, test_oe;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) vco_clk = ~vco_clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    synth_divider_chain i_synth_divider_chain (
        .ref_clk     (ref_clk),
        .vco_clk     (vco_clk),
        .pwr_dn      (pwr_dn),
        .ref_code    (ref_code),
        .main_code   (main_code),
        .swallow_val (swallow_val),
        .test_sel    (test_sel),
        .lock_in     (lock_in),
        .ref_pulse   (ref_pulse),
        .pc_pulse    (pc_pulse),
        .mod33       (mod33),
        .test_out    (test_out),
        .test_oe     (test_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic power_cycle();
        pwr_dn = 1;
        repeat (2) @(negedge ref_clk);
        pwr_dn = 0;
        #1;
    endtask

    task automatic measure_ref(output int first, output int gap, output int wide);
        int k = 0;
        while (!ref_pulse && k < 5000) begin @(negedge ref_clk); k++; end
        first = k;
        @(negedge ref_clk);
        wide = ref_pulse;
        k = 1;
        while (!ref_pulse && k < 5000) begin @(negedge ref_clk); k++; end
        gap = k;
    endtask

    task automatic measure_pc(output int first, output int gap, output int m33, output int wide);
        int k = 0;
        int h = 0;
        while (!pc_pulse && k < 5000) begin
            if (mod33) h++;
            @(negedge vco_clk);
            k++;
        end
        if (mod33) h++;
        first = k;
        m33 = h;
        @(negedge vco_clk);
        wide = pc_pulse;
        k = 1;
        while (!pc_pulse && k < 5000) begin @(negedge vco_clk); k++; end
        gap = k;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R6: reset state while power-down is held
        swallow_val = 5;
        test_sel = 3'b011;
        repeat (3) @(negedge ref_clk);
        #1;
        check(ref_pulse == 0, "R6 ref_pulse in power-down", ref_pulse, 0);
        check(pc_pulse == 0, "R6 pc_pulse in power-down", pc_pulse, 0);
        check(mod33 == 0, "R6 mod33 in power-down", mod33, 0);
        check(test_out == 0, "R6 slow copy in power-down", test_out, 0);
        test_sel = 3'b111;
        #1;
        check(test_out == 0, "R6 div2 copy in power-down", test_out, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge vco_clk);
                if (pc_pulse || ref_pulse || mod33) seen++;
            end
            check(seen == 0, "R6 no activity while held", seen, 0);
        end

        // Vector table: R1, R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            int rf, rg, rw, pf, pg, pm, pw;
            ref_code    = 2'(VEC[v][0]);
            main_code   = 2'(VEC[v][1]);
            swallow_val = 5'(VEC[v][2]);
            power_cycle();
            fork
                measure_ref(rf, rg, rw);
                measure_pc(pf, pg, pm, pw);
            join
            check(rf == VEC[v][3] - 1, "R1 first ref pulse", rf, VEC[v][3] - 1);
            check(rg == VEC[v][3], "R1 ref period", rg, VEC[v][3]);
            check(rw == 0, "R2 ref pulse width", rw, 0);
            check(pf == VEC[v][4] - 1, "R3 first pc pulse", pf, VEC[v][4] - 1);
            check(pg == VEC[v][4], "R3 pc period", pg, VEC[v][4]);
            check(pw == 0, "R4 pc pulse width", pw, 0);
            check(pm == 33 * VEC[v][2], "R5 mod33 high cycles", pm, 33 * VEC[v][2]);
        end

        // R9 and R7: lock routing and output enable
        test_sel = 3'b000; lock_in = 1; #1;
        check(test_out == 1, "R9 locked level", test_out, 1);
        check(test_oe == 1, "R7 oe driven", test_oe, 1);
        lock_in = 0; #1;
        check(test_out == 0, "R9 unlocked level", test_out, 0);
        test_sel = 3'b100; lock_in = 1; #1;
        check(test_out == 1, "R9 lock in hiz select", test_out, 1);
        check(test_oe == 0, "R7 oe released", test_oe, 0);

        // R7: reference pulse routed, R = 4
        ref_code = 2'b01; test_sel = 3'b001;
        power_cycle();
        check(test_out == 0, "R7 ref route idx0", test_out, 0);
        repeat (3) @(negedge ref_clk);
        check(test_out == 1, "R7 ref route idx3", test_out, 1);
        check(test_oe == 1, "R7 ref route oe", test_oe, 1);

        // R7: programmable pulse routed in hiz, N = 1024
        main_code = 2'b00; swallow_val = 0; test_sel = 3'b110;
        power_cycle();
        repeat (1022) @(negedge vco_clk);
        check(test_out == 0, "R7 pc route idx1022", test_out, 0);
        @(negedge vco_clk);
        check(test_out == 1, "R7 pc route idx1023", test_out, 1);
        check(test_oe == 0, "R7 pc route oe", test_oe, 0);

        // R8: divide-by-2 copy, R = 3
        ref_code = 2'b00; test_sel = 3'b111;
        power_cycle();
        repeat (2) @(negedge ref_clk);
        check(test_out == 0, "R8 div2 idx2", test_out, 0);
        @(negedge ref_clk);
        check(test_out == 1, "R8 div2 idx3", test_out, 1);
        repeat (3) @(negedge ref_clk);
        check(test_out == 0, "R8 div2 idx6", test_out, 0);

        // R8: divide-by-2048 copy, R = 3
        test_sel = 3'b011;
        power_cycle();
        repeat (3071) @(negedge ref_clk);
        check(test_out == 0, "R8 slow idx3071", test_out, 0);
        @(negedge ref_clk);
        check(test_out == 1, "R8 slow idx3072", test_out, 1);
        check(test_oe == 1, "R8 slow oe", test_oe, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule